// File: doc/BRIEF.md
# Interrupting 32-Pin General-Purpose I/O Controller

This block gives software control of 32 general-purpose pins through a small register window. Each pin can be an input or an output. The driven output values are never written as a whole word. Software changes them through a set port and a clear port, which take a one-hot or multi-bit mask. Because of this, two agents can change different pins without a read-modify-write race. Incoming pin levels pass through a two-stage synchronizer before they can be read back.

Every pin is also an interrupt source. Three per-pin masks choose its trigger:

- level or edge sensitivity;
- a both-edges override;
- a polarity inversion.

A detected event sets a pending bit, whether or not that pin is enabled. Software sees the pending bits in two forms: raw, and ANDed with the enable mask. It clears a pending bit by writing a one to it. All enabled pending bits are ORed onto one active-high interrupt line.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0. All pins are inputs (`pin_oe` = 0), no interrupt is enabled or pending, every trigger is rising-edge, and `irq` is 0.
- R2: The direction register (offset 0x08, read/write) drives `pin_oe` bit for bit, with 1 meaning output. The output-data register (offset 0x00, read only) drives `pin_out`.
- R3: Writing a mask to offset 0x10 sets those bits of the output data, and writing a mask to 0x14 clears them. Bits written as 0 keep their value.
- R4: Offset 0x04 returns `pin_in` after a two-flop synchronizer. A pin change held for two clock edges is visible there.
- R5: For an edge-sensitive pin (trigger bit 0 at offset 0x34), polarity bit 0 (offset 0x3C) latches a rising transition and polarity bit 1 latches a falling one. A transition in the other direction is ignored.
- R6: Both-edges bit 1 (offset 0x38) makes an edge-sensitive pin latch both rising and falling transitions, whatever its polarity bit.
- R7: Trigger bit 1 makes the pin level sensitive. It is pending while the synchronized level is high when polarity is 0, and while the level is low when polarity is 1.
- R8: A detected event sets the pin's bit in raw status (offset 0x24) even when its enable bit (offset 0x20) is 0. Masked status (offset 0x28) equals raw status ANDed with enable.
- R9: Writing 1 to a bit at offset 0x2C clears that pending bit, and writing 0 leaves it alone. A level-sensitive pin whose level is still active remains pending.
- R10: `irq` is 1 exactly when at least one pending bit has its enable bit set.
- R11: Offsets that are not mapped read as 0. Writes to read-only or unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte address of the register |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Driven output values |
| pin_oe | output | 32 | Output enable per pin, 1 = output |
| irq | output | 1 | Combined active-high interrupt |

## Verification
The assertions check some behaviour on every cycle:

- a set-port or clear-port write lands on the output data in the next cycle;
- the output data holds steady when no write occurs;
- `irq` stays low whenever the enable mask is zero.

The bench scenarios cover the rest. Edge and level detection under each trigger combination, synchronizer latency, a level source staying pending after an acknowledge, and the relation between raw and masked status all need sequences of pin changes and register accesses. The bench checks them against a model of pins, configuration and pending bits.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NPIN = 32,
  parameter int AW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq
);
  localparam logic [AW-1:0] A_DOUT = 6'h00, A_DIN = 6'h04, A_DIR = 6'h08,
                            A_SET = 6'h10, A_CLR = 6'h14, A_IEN = 6'h20,
                            A_RAW = 6'h24, A_MSK = 6'h28, A_ACK = 6'h2C,
                            A_TRG = 6'h34, A_BTH = 6'h38, A_POL = 6'h3C;

  logic [NPIN-1:0] dout_q, dir_q, ien_q, pend_q, trg_q, bth_q, pol_q;
  logic [NPIN-1:0] sync1_q, sync2_q, prev_q;
  logic [NPIN-1:0] rise, fall, edge_hit, lvl_hit, hit, ack;

  wire wr_set = bus_we && bus_addr == A_SET;
  wire wr_clr = bus_we && bus_addr == A_CLR;

  assign rise     = sync2_q & ~prev_q;
  assign fall     = ~sync2_q & prev_q;
  assign edge_hit = (bth_q & (rise | fall)) | (~bth_q & pol_q & fall) | (~bth_q & ~pol_q & rise);
  assign lvl_hit  = sync2_q ^ pol_q;
  assign hit      = (trg_q & lvl_hit) | (~trg_q & edge_hit);
  assign ack      = (bus_we && bus_addr == A_ACK) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      ien_q  <= '0;
      trg_q  <= '0;
      bth_q  <= '0;
      pol_q  <= '0;
    end else begin
      if (wr_set) dout_q <= dout_q | bus_wdata;
      if (wr_clr) dout_q <= dout_q & ~bus_wdata;
      if (bus_we) begin
        case (bus_addr)
          A_DIR:   dir_q <= bus_wdata;
          A_IEN:   ien_q <= bus_wdata;
          A_TRG:   trg_q <= bus_wdata;
          A_BTH:   bth_q <= bus_wdata;
          A_POL:   pol_q <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~ack) | hit;
  end

  always_comb begin
    case (bus_addr)
      A_DOUT:  bus_rdata = dout_q;
      A_DIN:   bus_rdata = sync2_q;
      A_DIR:   bus_rdata = dir_q;
      A_IEN:   bus_rdata = ien_q;
      A_RAW:   bus_rdata = pend_q;
      A_MSK:   bus_rdata = pend_q & ien_q;
      A_TRG:   bus_rdata = trg_q;
      A_BTH:   bus_rdata = bth_q;
      A_POL:   bus_rdata = pol_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pin_out = dout_q;
  assign pin_oe  = dir_q;
  assign irq     = |(pend_q & ien_q);
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NPIN = 32,
  parameter int AW   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_we,
  input logic [NPIN-1:0] bus_wdata,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] ien_q,
  input logic            irq
);
  a_r3_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 6'h10) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

  a_r3_clr_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 6'h14) |=> ((pin_out & $past(bus_wdata)) == '0));

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(pin_out));

  a_r10_quiet_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .ien_q(ien_q), .irq(irq));

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, pin_out, pin_oe;
  logic [31:0] pin_in = '0;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  logic        done = 0;

  always #2 clk = ~clk;

  gpio_irq_ctrl u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] hits(logic [31:0] po, logic [31:0] pn,
      logic [31:0] trg, logic [31:0] bth, logic [31:0] pol);
    logic [31:0] r = pn & ~po, f = po & ~pn, e;
    e = (bth & (r | f)) | (~bth & pol & f) | (~bth & ~pol & r);
    return (trg & (pn ^ pol)) | (~trg & e);
  endfunction

  initial begin
    #(4 * 200000);
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    n_chk++; n_bad++;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, dmod, p, trg, bth, pol, en, exp;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    foreach (v[i]) if (i < 16) begin
      rd(6'(i * 4), v);
      chk("R1 reset read", v, 0);
    end
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 direction
    wr(6'h08, 32'hA5A5_0F0F);
    rd(6'h08, v);
    chk("R2 dir readback", v, 32'hA5A5_0F0F);
    chk("R2 pin_oe", pin_oe, 32'hA5A5_0F0F);

    // R3 set/clear, R11 ignored writes
    dmod = 0;
    for (int k = 0; k < 24; k++) begin
      v = $urandom;
      if (k % 2 == 0) begin wr(6'h10, v); dmod |= v; end
      else            begin wr(6'h14, v); dmod &= ~v; end
      rd(6'h00, p);
      chk("R3 data-out", p, dmod);
      chk("R2 pin_out", pin_out, dmod);
    end
    wr(6'h00, 32'hFFFF_FFFF);
    wr(6'h3F, 32'hFFFF_FFFF);
    rd(6'h00, v);
    chk("R11 read-only data-out", v, dmod);
    rd(6'h30, v);
    chk("R11 unmapped reads 0", v, 0);

    // R4 synchronizer
    for (int k = 0; k < 4; k++) begin
      p = $urandom;
      @(negedge clk); pin_in = p;
      repeat (2) @(negedge clk);
      rd(6'h04, v);
      chk("R4 data-in", v, p);
    end
    @(negedge clk); pin_in = 0;
    settle();
    wr(6'h2C, 32'hFFFF_FFFF);

    // R5 rising edge, disabled: R8 raw vs masked
    @(negedge clk); pin_in[0] = 1; settle();
    rd(6'h24, v); chk("R8 raw set while disabled", v, 32'h1);
    rd(6'h28, v); chk("R8 masked zero", v, 0);
    chk("R10 irq low when disabled", {31'b0, irq}, 0);
    wr(6'h20, 32'h1);
    chk("R10 irq high", {31'b0, irq}, 1);
    wr(6'h2C, 32'h0);
    rd(6'h24, v); chk("R9 zero write keeps pending", v, 32'h1);
    wr(6'h2C, 32'h1);
    rd(6'h24, v); chk("R9 ack clears edge", v, 0);
    chk("R10 irq low after ack", {31'b0, irq}, 0);
    @(negedge clk); pin_in[0] = 0; settle();
    rd(6'h24, v); chk("R5 falling ignored in rising mode", v, 0);

    // R5 falling via polarity
    wr(6'h3C, 32'h2);
    @(negedge clk); pin_in[1] = 1; settle();
    rd(6'h24, v); chk("R5 rising ignored in falling mode", v, 0);
    @(negedge clk); pin_in[1] = 0; settle();
    rd(6'h24, v); chk("R5 falling latched", v, 32'h2);
    wr(6'h2C, 32'h2);

    // R6 both edges overrides polarity
    wr(6'h38, 32'h4); wr(6'h3C, 32'h4);
    @(negedge clk); pin_in[2] = 1; settle();
    rd(6'h24, v); chk("R6 rise in both mode", v, 32'h4);
    wr(6'h2C, 32'h4);
    @(negedge clk); pin_in[2] = 0; settle();
    rd(6'h24, v); chk("R6 fall in both mode", v, 32'h4);
    wr(6'h2C, 32'h4);

    // R7 level high, R9 re-assert
    wr(6'h38, 0); wr(6'h3C, 0); wr(6'h34, 32'h8);
    @(negedge clk); pin_in[3] = 1; settle();
    wr(6'h2C, 32'h8);
    rd(6'h24, v); chk("R9 active level stays pending", v, 32'h8);
    @(negedge clk); pin_in[3] = 0; settle();
    wr(6'h2C, 32'h8);
    rd(6'h24, v); chk("R7 inactive level clears", v, 0);
    wr(6'h3C, 32'h8); settle();
    rd(6'h24, v); chk("R7 active-low level", v, 32'h8);

    // random mix: R5 R6 R7 R8 R10
    p = pin_in;
    for (int k = 0; k < 60; k++) begin
      trg = $urandom; bth = $urandom; pol = $urandom; en = $urandom;
      wr(6'h34, trg); wr(6'h38, bth); wr(6'h3C, pol); wr(6'h20, en);
      wr(6'h2C, 32'hFFFF_FFFF);
      exp = trg & (p ^ pol);
      rd(6'h24, v); chk("R9 random ack", v, exp);
      v = $urandom;
      @(negedge clk); pin_in = v; settle();
      exp |= hits(p, v, trg, bth, pol);
      p = v;
      rd(6'h24, v); chk("R7 random raw", v, exp);
      rd(6'h28, v); chk("R8 random masked", v, exp & en);
      chk("R10 random irq", {31'b0, irq}, {31'b0, |(exp & en)});
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule